// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block runs the internal bus cycles that take a processor core into an interrupt routine and bring it back out. When an interrupt is accepted in idle, it first reads an information word from address zero. It then spends a short variable phase in which it may issue fetch reads, but only while the instruction queue can take them. Next it saves the flag word and the program counter on the stack, fetches the routine's two-word vector, and hands the new program counter, the updated flags and the lowered stack pointer back to the core in a single cycle.

A return request pops the two saved words, restores the program counter and the flags, and raises the stack pointer again. Instruction decode and the prefetch queue lie outside the block. The queue appears only as a readiness input. The bus is a simple single-master request/ready interface: the sequencer holds one access until the slave answers ready.

Top module: `irq_seq`

## Requirements
- R1: A request on `acc_req` seen in idle starts entry, and the first bus access is a read at address 0. The data returned by that read appears on `int_info` by the time `done` pulses.
- R2: Between the information read and the first push there are at most 3 fetch reads, all at address `pc_in[AW-1:0]`. A further fetch read is issued only when `q_ready` is high at the decision cycle. The phase ends as soon as `q_ready` is low or 3 reads have been made.
- R3: The saves are two writes in a fixed order. The first goes to SP-2 and carries the flag word in bits 15:8 and PC bits 23:16 in bits 7:0. The second goes to SP-4 and carries PC bits 15:0. SP is the `sp_in` value taken at acceptance.
- R4: After the saves, the sequencer reads the vector low word at `vec_addr` and then the high word at `vec_addr`+2. The new PC is {high word bits 7:0, low word}.
- R5: The entry flag word has the enable bit (bit 7) cleared and the priority field (bits 2:0) set to the accepted `acc_lvl`. All other bits equal `flg_in`.
- R6: `sp_wdata` is SP-4 at the end of entry and SP+4 at the end of return.
- R7: A request on `ret_req` seen in idle reads SP and then SP+2. It restores PC as {second word bits 7:0, first word} and the flags from bits 15:8 of the second word.
- R8: Each access holds `bus_req`, `bus_addr`, `bus_we` and `bus_wdata` unchanged until `bus_rdy` is sampled high. Only then does the next access begin.
- R9: `done` is a one-cycle pulse after the last access of an entry or return. `pc_we`, `flg_we` and `sp_we` pulse in that same cycle and at no other time.
- R10: Requests that arrive while busy are dropped and start no operation afterwards. When `acc_req` and `ret_req` arrive together in idle, only the entry runs.
- R11: After reset, `bus_req`, `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_req | input | 1 | Interrupt accepted, start entry |
| acc_lvl | input | IPL_W | Priority level of the accepted interrupt |
| ret_req | input | 1 | Start return from routine |
| vec_addr | input | AW | Address of the vector low word |
| sp_in | input | AW | Current stack pointer |
| pc_in | input | PCW | Current program counter |
| flg_in | input | FW | Current flag word |
| q_ready | input | 1 | Instruction queue can accept a fetch |
| bus_rdy | input | 1 | Slave completes the current access |
| bus_rdata | input | DW | Read data |
| bus_req | output | 1 | Access in progress |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | AW | Access address |
| bus_wdata | output | DW | Write data |
| busy | output | 1 | Sequence running |
| done | output | 1 | End-of-sequence pulse |
| int_info | output | DW | Word returned by the information read |
| pc_we | output | 1 | Load program counter |
| pc_wdata | output | PCW | New program counter |
| flg_we | output | 1 | Load flag word |
| flg_wdata | output | FW | New flag word |
| sp_we | output | 1 | Load stack pointer |
| sp_wdata | output | AW | New stack pointer |

## Verification
Entry and return can be requested in the same idle cycle. The bench raises both lines together and expects a bus trace that starts with the read at zero. It then expects the full entry script and silence after `done`. A second collision comes from holding both request lines high on every cycle while an entry is running, including through bus wait states. The recorded trace must match the single-entry script, and the bus must stay idle after `done`.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_INFO, S_IDEC, S_IRD, S_PSHF, S_PSHP,
    S_VLO, S_VHI, S_ENDE, S_POPP, S_POPF, S_ENDR
  } seq_st_t;
endpackage

// File: rtl/irq_slot_ctr.sv
module irq_slot_ctr #(
  parameter int MAX = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic step,
  input  logic q_ready,
  output logic more
);
  localparam int CW = $clog2(MAX + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (step)  cnt <= cnt + 1'b1;
  end

  assign more = q_ready && (cnt < CW'(MAX));

  // R2: a fetch slot is only taken while the queue is ready
  a_r2_step_needs_ready: assert property (@(posedge clk) disable iff (rst)
    step |-> q_ready);
endmodule

// File: rtl/irq_flag_mod.sv
module irq_flag_mod #(
  parameter int FW        = 8,
  parameter int IPL_W     = 3,
  parameter int IPL_LSB   = 0,
  parameter int IFLAG_POS = 7
) (
  input  logic [FW-1:0]    flg_in,
  input  logic [IPL_W-1:0] lvl,
  output logic [FW-1:0]    flg_out
);
  for (genvar i = 0; i < FW; i++) begin : g_bit
    if (i == IFLAG_POS) begin : g_en
      assign flg_out[i] = 1'b0;
    end else if (i >= IPL_LSB && i < IPL_LSB + IPL_W) begin : g_lvl
      assign flg_out[i] = lvl[i-IPL_LSB];
    end else begin : g_keep
      assign flg_out[i] = flg_in[i];
    end
  end
endmodule

// File: rtl/irq_bus_reg.sv
module irq_bus_reg #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          n_req,
  input  logic          n_we,
  input  logic [AW-1:0] n_addr,
  input  logic [DW-1:0] n_wdata,
  input  logic          bus_rdy,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else if (load) begin
      bus_req   <= n_req;
      bus_we    <= n_we;
      bus_addr  <= n_addr;
      bus_wdata <= n_wdata;
    end
  end

  // R8: an unanswered access keeps every field
  a_r8_hold_access: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_rdy) |=> (bus_req && $stable(bus_addr) &&
                               $stable(bus_we) && $stable(bus_wdata)));
endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_seq_pkg::*;
#(
  parameter int AW        = 20,
  parameter int DW        = 16,
  parameter int FW        = 8,
  parameter int PCW       = 24,
  parameter int IPL_W     = 3,
  parameter int IPL_LSB   = 0,
  parameter int IFLAG_POS = 7,
  parameter int MAX_SLOTS = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_req,
  input  logic [IPL_W-1:0] acc_lvl,
  input  logic             ret_req,
  input  logic [AW-1:0]    vec_addr,
  input  logic [AW-1:0]    sp_in,
  input  logic [PCW-1:0]   pc_in,
  input  logic [FW-1:0]    flg_in,
  input  logic             q_ready,
  input  logic             bus_rdy,
  input  logic [DW-1:0]    bus_rdata,
  output logic             bus_req,
  output logic             bus_we,
  output logic [AW-1:0]    bus_addr,
  output logic [DW-1:0]    bus_wdata,
  output logic             busy,
  output logic             done,
  output logic [DW-1:0]    int_info,
  output logic             pc_we,
  output logic [PCW-1:0]   pc_wdata,
  output logic             flg_we,
  output logic [FW-1:0]    flg_wdata,
  output logic             sp_we,
  output logic [AW-1:0]    sp_wdata
);
  localparam int HIW = PCW - DW;
  localparam logic [AW-1:0] WORD = AW'(2);
  localparam logic [AW-1:0] PAIR = AW'(4);

  seq_st_t          state, nst;
  logic [AW-1:0]    sp_base, vec_q;
  logic [PCW-1:0]   pc_q;
  logic [FW-1:0]    flg_q, flg_ent;
  logic [IPL_W-1:0] lvl_q;
  logic [DW-1:0]    lo_q;
  logic             xfer, more, step, start_ent, start_ret;
  logic             load, n_req, n_we;
  logic [AW-1:0]    n_addr;
  logic [DW-1:0]    n_wdata;

  assign xfer      = bus_req && bus_rdy;
  assign start_ent = (state == S_IDLE) && acc_req;
  assign start_ret = (state == S_IDLE) && !acc_req && ret_req;
  assign step      = (state == S_IDEC) && more;
  assign busy      = (state != S_IDLE);

  irq_slot_ctr #(.MAX(MAX_SLOTS)) u_slots (
    .clk(clk), .rst(rst), .clr(start_ent), .step(step),
    .q_ready(q_ready), .more(more)
  );

  irq_flag_mod #(.FW(FW), .IPL_W(IPL_W), .IPL_LSB(IPL_LSB),
                 .IFLAG_POS(IFLAG_POS)) u_flags (
    .flg_in(flg_q), .lvl(lvl_q), .flg_out(flg_ent)
  );

  irq_bus_reg #(.AW(AW), .DW(DW)) u_bus (
    .clk(clk), .rst(rst), .load(load), .n_req(n_req), .n_we(n_we),
    .n_addr(n_addr), .n_wdata(n_wdata), .bus_rdy(bus_rdy),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata)
  );

  always_comb begin
    nst     = state;
    load    = 1'b0;
    n_req   = 1'b0;
    n_we    = 1'b0;
    n_addr  = '0;
    n_wdata = '0;
    case (state)
      S_IDLE: begin
        if (acc_req) begin
          nst = S_INFO; load = 1'b1; n_req = 1'b1;
        end else if (ret_req) begin
          nst = S_POPP; load = 1'b1; n_req = 1'b1; n_addr = sp_in;
        end
      end
      S_INFO, S_IRD: if (xfer) begin nst = S_IDEC; load = 1'b1; end
      S_IDEC: begin
        load  = 1'b1;
        n_req = 1'b1;
        if (more) begin
          nst = S_IRD; n_addr = pc_q[AW-1:0];
        end else begin
          nst = S_PSHF; n_we = 1'b1; n_addr = sp_base - WORD;
          n_wdata = {flg_q, pc_q[PCW-1:DW]};
        end
      end
      S_PSHF: if (xfer) begin
        nst = S_PSHP; load = 1'b1; n_req = 1'b1; n_we = 1'b1;
        n_addr = sp_base - PAIR; n_wdata = pc_q[DW-1:0];
      end
      S_PSHP: if (xfer) begin
        nst = S_VLO; load = 1'b1; n_req = 1'b1; n_addr = vec_q;
      end
      S_VLO: if (xfer) begin
        nst = S_VHI; load = 1'b1; n_req = 1'b1; n_addr = vec_q + WORD;
      end
      S_VHI: if (xfer) begin nst = S_ENDE; load = 1'b1; end
      S_POPP: if (xfer) begin
        nst = S_POPF; load = 1'b1; n_req = 1'b1; n_addr = sp_base + WORD;
      end
      S_POPF: if (xfer) begin nst = S_ENDR; load = 1'b1; end
      S_ENDE, S_ENDR: nst = S_IDLE;
      default: nst = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      sp_base  <= '0;
      vec_q    <= '0;
      pc_q     <= '0;
      flg_q    <= '0;
      lvl_q    <= '0;
      lo_q     <= '0;
      int_info <= '0;
      done     <= 1'b0;
      pc_we    <= 1'b0;
      flg_we   <= 1'b0;
      sp_we    <= 1'b0;
      pc_wdata <= '0;
      flg_wdata <= '0;
      sp_wdata <= '0;
    end else begin
      state  <= nst;
      done   <= 1'b0;
      pc_we  <= 1'b0;
      flg_we <= 1'b0;
      sp_we  <= 1'b0;
      if (start_ent) begin
        sp_base <= sp_in;
        vec_q   <= vec_addr;
        pc_q    <= pc_in;
        flg_q   <= flg_in;
        lvl_q   <= acc_lvl;
      end
      if (start_ret) sp_base <= sp_in;
      if (state == S_INFO && xfer) int_info <= bus_rdata;
      if ((state == S_VLO || state == S_POPP) && xfer) lo_q <= bus_rdata;
      if (state == S_VHI && xfer) begin
        done <= 1'b1; pc_we <= 1'b1; flg_we <= 1'b1; sp_we <= 1'b1;
        pc_wdata  <= {bus_rdata[HIW-1:0], lo_q};
        flg_wdata <= flg_ent;
        sp_wdata  <= sp_base - PAIR;
      end
      if (state == S_POPF && xfer) begin
        done <= 1'b1; pc_we <= 1'b1; flg_we <= 1'b1; sp_we <= 1'b1;
        pc_wdata  <= {bus_rdata[HIW-1:0], lo_q};
        flg_wdata <= bus_rdata[DW-1 -: FW];
        sp_wdata  <= sp_base + PAIR;
      end
    end
  end

  // R1: acceptance opens with a read at address zero
  a_r1_info_first: assert property (@(posedge clk) disable iff (rst)
    start_ent |=> (bus_req && !bus_we && bus_addr == '0));

  // R9: done lasts one cycle, and core loads only ride on it
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r9_loads_on_done: assert property (@(posedge clk) disable iff (rst)
    (pc_we || flg_we || sp_we) |-> done);

  // R10: no operation can start from a busy state
  a_r10_no_restart: assert property (@(posedge clk) disable iff (rst)
    busy |=> !((state == S_INFO || state == S_POPP) && $past(state) != state));

  // R5: entry flags leave the enable bit clear and carry the taken level
  a_r5_entry_flags: assert property (@(posedge clk) disable iff (rst)
    (flg_we && state == S_ENDE) |->
      (!flg_wdata[IFLAG_POS] && flg_wdata[IPL_LSB +: IPL_W] == lvl_q));

  // R6: entry lowers the stack pointer by four
  a_r6_entry_sp: assert property (@(posedge clk) disable iff (rst)
    (sp_we && state == S_ENDE) |-> (sp_wdata + PAIR == sp_base));
endmodule

// File: tb/irq_seq_tb.sv
module irq_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 20, DW = 16, FW = 8, PCW = 24;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst, acc_req, ret_req, q_ready, bus_rdy;
  logic [2:0] acc_lvl;
  logic [AW-1:0] vec_addr, sp_in;
  logic [PCW-1:0] pc_in;
  logic [FW-1:0] flg_in;
  logic [DW-1:0] bus_rdata;
  logic bus_req, bus_we, busy, done, pc_we, flg_we, sp_we;
  logic [AW-1:0] bus_addr, sp_wdata;
  logic [DW-1:0] bus_wdata, int_info;
  logic [PCW-1:0] pc_wdata;
  logic [FW-1:0] flg_wdata;

  irq_seq u_dut (
    .clk(clk), .rst(rst), .acc_req(acc_req), .acc_lvl(acc_lvl),
    .ret_req(ret_req), .vec_addr(vec_addr), .sp_in(sp_in), .pc_in(pc_in),
    .flg_in(flg_in), .q_ready(q_ready), .bus_rdy(bus_rdy),
    .bus_rdata(bus_rdata), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .busy(busy), .done(done),
    .int_info(int_info), .pc_we(pc_we), .pc_wdata(pc_wdata),
    .flg_we(flg_we), .flg_wdata(flg_wdata), .sp_we(sp_we),
    .sp_wdata(sp_wdata)
  );

  int errs = 0, checks = 0, cyc = 0;
  int waits = 0, wcnt = 0, drop_after = 99, slots = 0;
  bit fresh = 1, in_entry = 0, ph_pend = 0, ph_we = 0;
  logic [AW-1:0] slot_addr, ph_addr;
  logic [DW-1:0] ph_data;
  logic [DW-1:0] mem [logic [AW-1:0]];
  logic [AW-1:0] t_addr[$];
  bit            t_we[$];
  logic [DW-1:0] t_data[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one cycle: bus slave model and access-hold observer, sampled at negedge
  task automatic tick();
    @(negedge clk);
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "R9", "watchdog expired", 64'(cyc), 64'd150000);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
    if (rst) begin
      bus_rdy = 1'b0; fresh = 1; ph_pend = 0;
      return;
    end
    if (ph_pend)
      chk(bus_req && bus_addr == ph_addr && bus_we == ph_we &&
          (!ph_we || bus_wdata == ph_data), "R8", "access held while waiting",
          64'(bus_addr), 64'(ph_addr));
    if (bus_rdy) fresh = 1;
    bus_rdy = 1'b0;
    if (bus_req) begin
      if (fresh) begin wcnt = waits; fresh = 0; end
      if (wcnt == 0) begin
        bus_rdy = 1'b1;
        bus_rdata = (!bus_we && mem.exists(bus_addr)) ? mem[bus_addr] : '0;
        if (bus_we) mem[bus_addr] = bus_wdata;
        t_addr.push_back(bus_addr); t_we.push_back(bus_we);
        t_data.push_back(bus_wdata);
        if (in_entry && !bus_we && bus_addr == slot_addr) begin
          slots++;
          if (slots >= drop_after) q_ready = 1'b0;
        end
      end else wcnt--;
    end
    ph_pend = bus_req && !bus_rdy;
    ph_addr = bus_addr; ph_we = bus_we; ph_data = bus_wdata;
  endtask

  function automatic logic [FW-1:0] ent_flags(logic [FW-1:0] f, logic [2:0] l);
    logic [FW-1:0] r = f;
    r[7] = 1'b0;
    r[2:0] = l;
    return r;
  endfunction

  task automatic cmp_trace(input logic [AW-1:0] ea[$], input bit ew[$],
                           input logic [DW-1:0] ed[$], input string tg[$]);
    chk(t_addr.size() == ea.size(), "R2", "access count",
        64'(t_addr.size()), 64'(ea.size()));
    for (int i = 0; i < ea.size() && i < t_addr.size(); i++) begin
      chk(t_addr[i] == ea[i] && t_we[i] == ew[i], tg[i], "access address/dir",
          {t_we[i], 31'd0, 12'd0, t_addr[i]}, {ew[i], 31'd0, 12'd0, ea[i]});
      if (ew[i]) chk(t_data[i] == ed[i], tg[i], "write data",
                     64'(t_data[i]), 64'(ed[i]));
    end
  endtask

  task automatic wait_done(input bit poke, output bit got);
    got = 0;
    for (int n = 0; n < 400; n++) begin
      tick();
      if (done) begin got = 1; break; end
      if (poke && busy) begin acc_req = 1'b1; ret_req = 1'b1; end
    end
    acc_req = 1'b0; ret_req = 1'b0;
  endtask

  task automatic run_entry(input logic [AW-1:0] sp, input logic [AW-1:0] vec,
                           input logic [PCW-1:0] pc, input logic [FW-1:0] flg,
                           input logic [2:0] lvl, input int qmode,
                           input bit both, input bit poke,
                           input logic [DW-1:0] info, input logic [DW-1:0] lo,
                           input logic [DW-1:0] hi);
    logic [AW-1:0] ea[$];
    bit ew[$];
    logic [DW-1:0] ed[$];
    string tg[$];
    int k;
    bit got;
    k = (qmode > 3) ? 3 : qmode;
    mem[0] = info; mem[vec] = lo; mem[vec + 2] = hi;
    t_addr.delete(); t_we.delete(); t_data.delete();
    slots = 0; slot_addr = pc[AW-1:0]; in_entry = 1; drop_after = qmode;
    q_ready = (qmode > 0);
    sp_in = sp; vec_addr = vec; pc_in = pc; flg_in = flg; acc_lvl = lvl;
    acc_req = 1'b1; ret_req = both;
    tick();
    acc_req = 1'b0; ret_req = 1'b0;
    wait_done(poke, got);
    chk(got, "R9", "done pulse after entry", 64'(got), 64'd1);
    chk(pc_we && pc_wdata == {hi[7:0], lo}, "R4", "new PC",
        64'(pc_wdata), 64'({hi[7:0], lo}));
    chk(flg_we && flg_wdata == ent_flags(flg, lvl), "R5", "entry flags",
        64'(flg_wdata), 64'(ent_flags(flg, lvl)));
    chk(sp_we && sp_wdata == sp - 4, "R6", "entry SP",
        64'(sp_wdata), 64'(sp - 4));
    chk(int_info == info, "R1", "information word", 64'(int_info), 64'(info));
    ea.push_back('0); ew.push_back(0); ed.push_back('0); tg.push_back("R1");
    for (int i = 0; i < k; i++) begin
      ea.push_back(pc[AW-1:0]); ew.push_back(0); ed.push_back('0);
      tg.push_back("R2");
    end
    ea.push_back(sp - 2); ew.push_back(1); ed.push_back({flg, pc[23:16]});
    tg.push_back("R3");
    ea.push_back(sp - 4); ew.push_back(1); ed.push_back(pc[15:0]);
    tg.push_back("R3");
    ea.push_back(vec); ew.push_back(0); ed.push_back('0); tg.push_back("R4");
    ea.push_back(vec + 2); ew.push_back(0); ed.push_back('0); tg.push_back("R4");
    cmp_trace(ea, ew, ed, tg);
    tick();
    chk(!done && !pc_we && !flg_we && !sp_we, "R9", "pulse length one cycle",
        {done, pc_we, flg_we, sp_we}, 64'd0);
    if (poke || both)
      for (int i = 0; i < 6; i++) begin
        tick();
        chk(!bus_req && !busy, "R10", "dropped request started nothing",
            {bus_req, busy}, 64'd0);
      end
    in_entry = 0;
  endtask

  task automatic run_ret(input logic [AW-1:0] sp, input logic [PCW-1:0] epc,
                         input logic [FW-1:0] eflg);
    logic [AW-1:0] ea[$];
    bit ew[$];
    logic [DW-1:0] ed[$];
    string tg[$];
    bit got;
    t_addr.delete(); t_we.delete(); t_data.delete();
    sp_in = sp; ret_req = 1'b1;
    tick();
    ret_req = 1'b0;
    wait_done(1'b0, got);
    chk(got, "R9", "done pulse after return", 64'(got), 64'd1);
    chk(pc_we && pc_wdata == epc, "R7", "restored PC", 64'(pc_wdata), 64'(epc));
    chk(flg_we && flg_wdata == eflg, "R7", "restored flags",
        64'(flg_wdata), 64'(eflg));
    chk(sp_we && sp_wdata == sp + 4, "R6", "return SP",
        64'(sp_wdata), 64'(sp + 4));
    ea.push_back(sp); ew.push_back(0); ed.push_back('0); tg.push_back("R7");
    ea.push_back(sp + 2); ew.push_back(0); ed.push_back('0); tg.push_back("R7");
    cmp_trace(ea, ew, ed, tg);
    tick();
    chk(!done && !pc_we, "R9", "return pulse length", {done, pc_we}, 64'd0);
  endtask

  initial begin
    rst = 1'b1; acc_req = 0; ret_req = 0; q_ready = 0; bus_rdy = 0;
    acc_lvl = '0; vec_addr = '0; sp_in = '0; pc_in = '0; flg_in = '0;
    bus_rdata = '0; slot_addr = '0; ph_addr = '0; ph_data = '0;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    chk(!bus_req && !busy && !done, "R11", "idle after reset",
        {bus_req, busy, done}, 64'd0);

    waits = 0;
    run_entry(20'h00400, 20'h0FFC0, 24'h123456, 8'hC9, 3'd5, 0, 0, 0,
              16'h00AB, 16'h7788, 16'hFF42);
    run_ret(20'h003FC, 24'h123456, 8'hC9);

    waits = 2;
    run_entry(20'h01000, 20'h0FF80, 24'hAB0010, 8'h38, 3'd2, 1, 0, 0,
              16'h1234, 16'h0200, 16'h0011);
    run_ret(20'h00FFC, 24'hAB0010, 8'h38);

    waits = 1;
    run_entry(20'h00802, 20'h0FF00, 24'h5F9ABC, 8'h87, 3'd7, 3, 0, 1,
              16'hBEEF, 16'h4444, 16'h00A0);
    waits = 0;
    run_ret(20'h007FE, 24'h5F9ABC, 8'h87);

    waits = 3;
    run_entry(20'h0C000, 20'h0FE40, 24'h0077F0, 8'hFF, 3'd1, 5, 1, 0,
              16'h0F0F, 16'hCAFE, 16'h1299);
    run_ret(20'h0BFFC, 24'h0077F0, 8'hFF);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule